// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block is the command-register state machine of a byte-wide parallel NOR flash model. It watches bus write cycles. Each write is presented for one clock as a full byte address and a data byte. The block matches them against unlock sequences and issues one-cycle requests to an embedded-operation engine. The requests are byte program, whole-array erase, sector erase (with a mask of the selected sectors), erase suspend, erase resume and return-to-read. It also enters an identifier mode, in which a read selects a manufacturer or device code.

After a sector-erase command the block opens a timed load window. Further sector-erase writes add sectors to the mask, and each one restarts the window. When the window runs out, the erase request goes out with the whole mask. The set of accepted writes depends on the mode. A running program or whole-array erase ignores everything. A running sector erase accepts only suspend. A suspended erase accepts only resume and byte program. The engine reports the end of an operation with a one-cycle `op_done` pulse.

Top module: `nor_cmd_seq`

## Requirements
- R1: The writes AAh at 555h, 55h at 2AAh, A0h at 555h, then any byte at any address raise `req_prog` for one cycle after the fourth write, with `prog_addr`/`prog_data` holding that write's address and data. At most one of the program, whole-erase, sector-erase, resume and return-to-read requests is high in any cycle.
- R2: AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, 10h/555h raise `req_chip_erase` for one cycle after the sixth write.
- R3: The same five-write prefix followed by 30h at any address opens the load window. `win_open` goes to 1, and `sect_mask` holds only the bit numbered by address bits 18..16.
- R4: Inside the window, each 30h write ORs its sector bit into `sect_mask` and restarts the window. When WIN_CYCLES clock edges pass with no write after the last one, `req_sect_erase` pulses with the accumulated mask and `win_open` drops.
- R5: Inside the window, a write whose data is neither 30h nor B0h raises `req_reset`, closes the window and issues no erase request.
- R6: A B0h write inside the window closes it at once. `req_sect_erase` (with the mask) and `req_suspend` pulse in the same cycle, and the block is then suspended.
- R7: AAh/555h, 55h/2AAh, 90h/555h set `id_active`. While it is set, `id_byte` is C2h for `rd_addr_lo`=00, A4h for 01, and 00h for 1x. Outside that mode `id_byte` is 00h.
- R8: From read or identifier mode, an F0h write that breaks or starts a sequence raises `req_reset` and clears `id_active`. Any other wrong address, data or order drops the partial sequence and clears `id_active` with no request. A later write does not resume the dropped sequence.
- R9: Only address bits 10..0 are compared with 555h and 2AAh. Bits 18..11 of the unlock writes have no effect.
- R10: While a program or whole-array erase is running (from its request until `op_done`), every write is ignored and issues no request.
- R11: While a sector erase is running, only B0h is accepted: it raises `req_suspend` and the block becomes suspended. F0h, 30h and command sequences issue nothing.
- R12: While suspended, a 30h write at sequence start raises `req_resume` and the erase runs again. The program sequence is accepted and raises `req_prog`, and its `op_done` returns the block to suspended. F0h and identifier or erase sequences issue nothing.
- R13: A 30h write outside the suspended state issues no resume request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One bus write cycle this clock |
| wr_addr | input | 19 | Write byte address |
| wr_data | input | 8 | Write data byte |
| op_done | input | 1 | Engine finished the running operation |
| rd_addr_lo | input | 2 | Low two read address bits for identifier selection |
| req_prog | output | 1 | Byte program request pulse |
| req_chip_erase | output | 1 | Whole-array erase request pulse |
| req_sect_erase | output | 1 | Sector erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| req_reset | output | 1 | Return-to-read request pulse |
| prog_addr | output | 19 | Address of the last program request |
| prog_data | output | 8 | Data of the last program request |
| sect_mask | output | 8 | Selected sectors, one bit per sector |
| id_active | output | 1 | Identifier mode active |
| id_byte | output | 8 | Identifier code for the current read address |
| win_open | output | 1 | Sector load window open |

## Verification
The hardest situations to reach are the suspended sub-modes: a program started while an erase is suspended, then a resume after that program has completed. Reaching them takes a six-write sector erase, a full window expiry, a suspend, a four-write program and two engine completions, all in order. The bench drives this chain directly and probes the rejected writes at each step. It times the window against the last accepted sector write, and ends with a long seeded random run of non-unlock writes in read mode.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        M_READ, M_ID, M_WIN, M_LOCK, M_ERASE, M_SUSP, M_SUSP_PROG
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE, S_U1, S_U2, S_PDATA, S_E1, S_E2, S_E3
    } step_e;

    typedef enum logic [3:0] {
        K_AA, K_55, K_A0, K_80, K_90, K_10, K_30, K_B0, K_F0, K_OTHER
    } kind_e;

    typedef struct packed {
        logic  at_555;
        logic  at_2aa;
        kind_e kind;
    } wr_class_t;

    typedef struct packed {
        logic prog;
        logic chip;
        logic sect;
        logic susp;
        logic resume;
        logic reset;
    } req_t;

    function automatic kind_e byte_kind(input logic [7:0] d);
        case (d)
            8'hAA:   return K_AA;
            8'h55:   return K_55;
            8'hA0:   return K_A0;
            8'h80:   return K_80;
            8'h90:   return K_90;
            8'h10:   return K_10;
            8'h30:   return K_30;
            8'hB0:   return K_B0;
            8'hF0:   return K_F0;
            default: return K_OTHER;
        endcase
    endfunction

    function automatic logic runs_op(input mode_e m);
        return (m == M_LOCK) || (m == M_ERASE) || (m == M_SUSP_PROG);
    endfunction

endpackage

// File: rtl/nor_cmd_classify.sv
module nor_cmd_classify
    import nor_cmd_pkg::*;
#(
    parameter int CMP_W = 11
) (
    input  logic [CMP_W-1:0] addr_lo,
    input  logic [7:0]       data,
    output wr_class_t        cls
);
    localparam logic [CMP_W-1:0] UNLOCK_A = CMP_W'(11'h555);
    localparam logic [CMP_W-1:0] UNLOCK_B = CMP_W'(11'h2AA);

    always_comb begin
        cls.at_555 = (addr_lo == UNLOCK_A);
        cls.at_2aa = (addr_lo == UNLOCK_B);
        cls.kind   = byte_kind(data);
    end
endmodule

// File: rtl/nor_erase_window.sv
module nor_erase_window #(
    parameter int SECT_W     = 3,
    parameter int WIN_CYCLES = 30
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   add,
    input  logic                   run,
    input  logic                   touch,
    input  logic [SECT_W-1:0]      sect,
    output logic [(1<<SECT_W)-1:0] mask,
    output logic                   expire
);
    localparam int NSECT = 1 << SECT_W;
    localparam int CNT_W = $clog2(WIN_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic [NSECT-1:0] dec;

    for (genvar g = 0; g < NSECT; g++) begin : g_dec
        assign dec[g] = (sect == SECT_W'(g));
    end

    assign expire = run && !touch && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            mask <= '0;
        end else begin
            if (start || add) begin
                cnt <= '0;
            end else if (run && cnt != LAST) begin
                cnt <= cnt + 1'b1;
            end
            if (start) begin
                mask <= dec;
            end else if (add) begin
                mask <= mask | dec;
            end
        end
    end

    AST_WIN_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);                                                   // R4
    AST_WIN_START_ONE: assert property (@(posedge clk) disable iff (rst)
        start |=> $countones(mask) == 1);                               // R3
    AST_WIN_MASK_GROW: assert property (@(posedge clk) disable iff (rst)
        (run && add) |=> ((mask | $past(mask)) == mask));               // R4
endmodule

// File: rtl/nor_id_mux.sv
module nor_id_mux #(
    parameter logic [7:0] MFR_ID = 8'hC2,
    parameter logic [7:0] DEV_ID = 8'hA4
) (
    input  logic       en,
    input  logic [1:0] sel,
    output logic [7:0] id_byte
);
    always_comb begin
        if (!en || sel[1]) begin
            id_byte = 8'h00;
        end else begin
            id_byte = sel[0] ? DEV_ID : MFR_ID;
        end
    end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int         ADDR_W     = 19,
    parameter int         CMP_W      = 11,
    parameter int         SECT_W     = 3,
    parameter int         WIN_CYCLES = 30,
    parameter logic [7:0] MFR_ID     = 8'hC2,
    parameter logic [7:0] DEV_ID     = 8'hA4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_valid,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic                   op_done,
    input  logic [1:0]             rd_addr_lo,
    output logic                   req_prog,
    output logic                   req_chip_erase,
    output logic                   req_sect_erase,
    output logic                   req_suspend,
    output logic                   req_resume,
    output logic                   req_reset,
    output logic [ADDR_W-1:0]      prog_addr,
    output logic [7:0]             prog_data,
    output logic [(1<<SECT_W)-1:0] sect_mask,
    output logic                   id_active,
    output logic [7:0]             id_byte,
    output logic                   win_open
);
    localparam int NSECT = 1 << SECT_W;

    mode_e       mode_q, mode_n;
    step_e       step_q, step_n;
    req_t        req_q, req_n;
    wr_class_t   cls;
    logic        win_start, win_add, win_expire, take_prog;
    logic        finish, susp, u1, u2, rej;
    logic [ADDR_W-1:0] prog_addr_q;
    logic [7:0]        prog_data_q;

    nor_cmd_classify #(.CMP_W(CMP_W)) u_cls (
        .addr_lo (wr_addr[CMP_W-1:0]),
        .data    (wr_data),
        .cls     (cls)
    );

    nor_erase_window #(.SECT_W(SECT_W), .WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk    (clk),
        .rst    (rst),
        .start  (win_start),
        .add    (win_add),
        .run    (mode_q == M_WIN),
        .touch  (wr_valid),
        .sect   (wr_addr[ADDR_W-1 -: SECT_W]),
        .mask   (sect_mask),
        .expire (win_expire)
    );

    nor_id_mux #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
        .en      (mode_q == M_ID),
        .sel     (rd_addr_lo),
        .id_byte (id_byte)
    );

    always_comb begin
        mode_n    = mode_q;
        step_n    = step_q;
        req_n     = '0;
        win_start = 1'b0;
        win_add   = 1'b0;
        take_prog = 1'b0;
        rej       = 1'b0;
        finish    = op_done && runs_op(mode_q);
        susp      = (mode_q == M_SUSP);
        u1        = cls.at_555 && (cls.kind == K_AA);
        u2        = cls.at_2aa && (cls.kind == K_55);
        if (finish) begin
            mode_n = (mode_q == M_SUSP_PROG) ? M_SUSP : M_READ;
            step_n = S_IDLE;
        end else if (mode_q == M_WIN && win_expire) begin
            req_n.sect = 1'b1;
            mode_n     = M_ERASE;
        end else if (wr_valid) begin
            case (mode_q)
                M_ERASE: begin
                    if (cls.kind == K_B0) begin
                        req_n.susp = 1'b1;
                        mode_n     = M_SUSP;
                        step_n     = S_IDLE;
                    end
                end
                M_WIN: begin
                    if (cls.kind == K_30) begin
                        win_add = 1'b1;
                    end else if (cls.kind == K_B0) begin
                        req_n.sect = 1'b1;
                        req_n.susp = 1'b1;
                        mode_n     = M_SUSP;
                    end else begin
                        req_n.reset = 1'b1;
                        mode_n      = M_READ;
                    end
                end
                M_READ, M_ID, M_SUSP: begin
                    case (step_q)
                        S_IDLE: begin
                            if (u1) begin
                                step_n = S_U1;
                            end else if (susp && cls.kind == K_30) begin
                                req_n.resume = 1'b1;
                                mode_n       = M_ERASE;
                            end else begin
                                rej = 1'b1;
                            end
                        end
                        S_U1: begin
                            if (u2) step_n = S_U2;
                            else    rej    = 1'b1;
                        end
                        S_U2: begin
                            if (cls.at_555 && cls.kind == K_A0) begin
                                step_n = S_PDATA;
                            end else if (!susp && cls.at_555 && cls.kind == K_90) begin
                                mode_n = M_ID;
                                step_n = S_IDLE;
                            end else if (!susp && cls.at_555 && cls.kind == K_80) begin
                                step_n = S_E1;
                            end else begin
                                rej = 1'b1;
                            end
                        end
                        S_PDATA: begin
                            req_n.prog = 1'b1;
                            take_prog  = 1'b1;
                            mode_n     = susp ? M_SUSP_PROG : M_LOCK;
                            step_n     = S_IDLE;
                        end
                        S_E1: begin
                            if (u1) step_n = S_E2;
                            else    rej    = 1'b1;
                        end
                        S_E2: begin
                            if (u2) step_n = S_E3;
                            else    rej    = 1'b1;
                        end
                        S_E3: begin
                            if (cls.at_555 && cls.kind == K_10) begin
                                req_n.chip = 1'b1;
                                mode_n     = M_LOCK;
                                step_n     = S_IDLE;
                            end else if (cls.kind == K_30) begin
                                win_start = 1'b1;
                                mode_n    = M_WIN;
                                step_n    = S_IDLE;
                            end else begin
                                rej = 1'b1;
                            end
                        end
                        default: rej = 1'b1;
                    endcase
                    if (rej) begin
                        step_n = S_IDLE;
                        if (!susp) begin
                            mode_n      = M_READ;
                            req_n.reset = (cls.kind == K_F0);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= M_READ;
            step_q      <= S_IDLE;
            req_q       <= '0;
            prog_addr_q <= '0;
            prog_data_q <= '0;
        end else begin
            mode_q <= mode_n;
            step_q <= step_n;
            req_q  <= req_n;
            if (take_prog) begin
                prog_addr_q <= wr_addr;
                prog_data_q <= wr_data;
            end
        end
    end

    assign req_prog       = req_q.prog;
    assign req_chip_erase = req_q.chip;
    assign req_sect_erase = req_q.sect;
    assign req_suspend    = req_q.susp;
    assign req_resume     = req_q.resume;
    assign req_reset      = req_q.reset;
    assign prog_addr      = prog_addr_q;
    assign prog_data      = prog_data_q;
    assign id_active      = (mode_q == M_ID);
    assign win_open       = (mode_q == M_WIN);

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_prog, req_chip_erase, req_sect_erase, req_resume, req_reset}));  // R1
    AST_PROG_SRC: assert property (@(posedge clk) disable iff (rst)
        req_prog |-> $past(step_q) == S_PDATA);                                        // R1
    AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_LOCK) |=> !(req_prog || req_chip_erase || req_sect_erase ||
                                 req_suspend || req_resume || req_reset));              // R10
    AST_ERASE_ONLY_SUSP: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_ERASE) |=> !(req_prog || req_chip_erase || req_sect_erase ||
                                  req_resume || req_reset));                            // R11
    AST_RESUME_SRC: assert property (@(posedge clk) disable iff (rst)
        req_resume |-> $past(mode_q) == M_SUSP);                                       // R12
    AST_SECT_SRC: assert property (@(posedge clk) disable iff (rst)
        req_sect_erase |-> $past(mode_q) == M_WIN);                                    // R4
    AST_ID_QUIET: assert property (@(posedge clk) disable iff (rst)
        (id_byte != 8'h00) |-> id_active);                                             // R7
endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        op_done = 1'b0;
    logic [1:0]  rd_addr_lo = '0;
    logic        req_prog, req_chip_erase, req_sect_erase, req_suspend, req_resume, req_reset;
    logic [18:0] prog_addr;
    logic [7:0]  prog_data, sect_mask, id_byte;
    logic        id_active, win_open;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [5:0] Q_NONE = 6'b000000;
    localparam logic [5:0] Q_PROG = 6'b100000;
    localparam logic [5:0] Q_CHIP = 6'b010000;
    localparam logic [5:0] Q_SECT = 6'b001000;
    localparam logic [5:0] Q_SUSP = 6'b000100;
    localparam logic [5:0] Q_RES  = 6'b000010;
    localparam logic [5:0] Q_RST  = 6'b000001;

    wire [5:0] reqv = {req_prog, req_chip_erase, req_sect_erase, req_suspend, req_resume, req_reset};

    always #2 clk = ~clk;

    nor_cmd_seq u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .op_done(op_done), .rd_addr_lo(rd_addr_lo),
        .req_prog(req_prog), .req_chip_erase(req_chip_erase), .req_sect_erase(req_sect_erase),
        .req_suspend(req_suspend), .req_resume(req_resume), .req_reset(req_reset),
        .prog_addr(prog_addr), .prog_data(prog_data), .sect_mask(sect_mask),
        .id_active(id_active), .id_byte(id_byte), .win_open(win_open)
    );

    function automatic logic [7:0] sect_bit(input logic [18:0] a);
        return 8'd1 << a[18:16];
    endfunction

    function automatic logic [5:0] idle_expect(input logic [7:0] d);
        return (d == 8'hF0) ? Q_RST : Q_NONE;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        op_done = 1'b1;
        @(posedge clk);
        #1;
        op_done = 1'b0;
    endtask

    task automatic unlock(input logic [7:0] hi);
        wr({hi, 11'h555}, 8'hAA);
        wr({hi, 11'h2AA}, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock(8'h00);
        wr(19'h00555, 8'h80);
        unlock(8'h00);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  d;
        logic [18:0] a;
        bit          bad;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // reset state
        chk("R1 reset requests", reqv, Q_NONE);
        chk("R7 reset id_active", id_active, 0);
        chk("R3 reset win_open", win_open, 0);
        chk("R3 reset mask", sect_mask, 0);

        // R1 program
        unlock(8'h00);
        wr(19'h00555, 8'hA0);
        chk("R1 no request before data", reqv, Q_NONE);
        wr(19'h12345, 8'h5A);
        chk("R1 program request", reqv, Q_PROG);
        chk("R1 program address", prog_addr, 19'h12345);
        chk("R1 program data", prog_data, 8'h5A);
        // R10 busy program ignores all
        wr(19'h00000, 8'hF0);
        chk("R10 reset ignored while busy", reqv, Q_NONE);
        unlock(8'h00);
        wr(19'h00555, 8'hA0);
        wr(19'h00111, 8'h33);
        chk("R10 program ignored while busy", reqv, Q_NONE);
        chk("R10 program address kept", prog_addr, 19'h12345);
        done_pulse();
        // R9 upper address bits on unlock writes are don't-care
        wr(19'h7F555, 8'hAA);
        wr(19'h3A2AA, 8'h55);
        wr(19'h51555, 8'hA0);
        wr(19'h6ABCD, 8'hC3);
        chk("R9 program with high bits set", reqv, Q_PROG);
        chk("R9 program address", prog_addr, 19'h6ABCD);
        done_pulse();

        // R2 chip erase
        erase_prefix();
        chk("R2 no request at fifth write", reqv, Q_NONE);
        wr(19'h00555, 8'h10);
        chk("R2 chip erase request", reqv, Q_CHIP);
        wr(19'h00000, 8'hB0);
        chk("R10 suspend ignored during chip erase", reqv, Q_NONE);
        done_pulse();

        // R7 identifier mode
        unlock(8'h00);
        wr(19'h00555, 8'h90);
        chk("R7 id mode entered", id_active, 1);
        rd_addr_lo = 2'b00; #1;
        chk("R7 manufacturer code", id_byte, 8'hC2);
        rd_addr_lo = 2'b01; #1;
        chk("R7 device code", id_byte, 8'hA4);
        rd_addr_lo = 2'b10; #1;
        chk("R7 high select bit", id_byte, 8'h00);
        wr(19'h00000, 8'hF0);
        chk("R8 reset request", reqv, Q_RST);
        chk("R8 id mode left", id_active, 0);
        rd_addr_lo = 2'b01; #1;
        chk("R7 no code outside id mode", id_byte, 8'h00);
        unlock(8'h00);
        wr(19'h00555, 8'h90);
        wr(19'h00555, 8'h55);
        chk("R8 wrong write no request", reqv, Q_NONE);
        chk("R8 wrong write leaves id mode", id_active, 0);

        // R8 wrong order / wrong address
        wr(19'h00555, 8'hAA);
        wr(19'h00555, 8'hAA);
        wr(19'h002AA, 8'h55);
        wr(19'h00555, 8'hA0);
        wr(19'h00100, 8'h77);
        chk("R8 broken order gives no program", reqv, Q_NONE);
        wr(19'h00556, 8'hAA);
        wr(19'h002AA, 8'h55);
        wr(19'h00555, 8'hA0);
        wr(19'h00100, 8'h77);
        chk("R8 wrong address gives no program", reqv, Q_NONE);

        // R13 resume in read mode
        wr(19'h00000, 8'h30);
        chk("R13 resume outside suspend", reqv, Q_NONE);

        // R3/R4 sector load window
        erase_prefix();
        wr(19'h21234, 8'h30);
        chk("R3 window open", win_open, 1);
        chk("R3 first sector mask", sect_mask, sect_bit(19'h21234));
        chk("R3 no request yet", reqv, Q_NONE);
        repeat (10) @(posedge clk);
        #1;
        wr(19'h50000, 8'h30);
        chk("R4 sector added", sect_mask, 8'h24);
        bad = 1'b0;
        for (int i = 0; i < 29; i++) begin
            @(posedge clk);
            #1;
            if (reqv !== Q_NONE || win_open !== 1'b1) bad = 1'b1;
        end
        chk("R4 window still open before expiry", bad, 0);
        @(posedge clk);
        #1;
        chk("R4 sector erase at expiry", reqv, Q_SECT);
        chk("R4 mask at expiry", sect_mask, 8'h24);
        chk("R4 window closed", win_open, 0);

        // R11 erase running
        wr(19'h00000, 8'hF0);
        chk("R11 reset ignored during erase", reqv, Q_NONE);
        unlock(8'h00);
        wr(19'h00555, 8'hA0);
        wr(19'h00200, 8'h11);
        chk("R11 program ignored during erase", reqv, Q_NONE);
        wr(19'h00000, 8'h30);
        chk("R11 resume ignored during erase", reqv, Q_NONE);
        wr(19'h00000, 8'hB0);
        chk("R11 suspend accepted", reqv, Q_SUSP);

        // R12 suspended
        wr(19'h00000, 8'hF0);
        chk("R12 reset ignored while suspended", reqv, Q_NONE);
        unlock(8'h00);
        wr(19'h00555, 8'h90);
        chk("R12 id entry refused while suspended", id_active, 0);
        wr(19'h00000, 8'h30);
        chk("R12 resume", reqv, Q_RES);
        wr(19'h00000, 8'hB0);
        chk("R11 second suspend", reqv, Q_SUSP);
        unlock(8'h00);
        wr(19'h00555, 8'hA0);
        wr(19'h61111, 8'h9C);
        chk("R12 program while suspended", reqv, Q_PROG);
        chk("R12 program address while suspended", prog_addr, 19'h61111);
        wr(19'h00000, 8'h30);
        chk("R12 resume ignored during suspended program", reqv, Q_NONE);
        done_pulse();
        wr(19'h00000, 8'h30);
        chk("R12 resume after suspended program", reqv, Q_RES);
        done_pulse();

        // R5 abort window
        erase_prefix();
        wr(19'h10000, 8'h30);
        wr(19'h002AA, 8'h55);
        chk("R5 other write resets", reqv, Q_RST);
        chk("R5 window closed", win_open, 0);
        bad = 1'b0;
        for (int i = 0; i < 35; i++) begin
            @(posedge clk);
            #1;
            if (reqv !== Q_NONE) bad = 1'b1;
        end
        chk("R5 no erase after abort", bad, 0);

        // R6 suspend inside window
        erase_prefix();
        wr(19'h70000, 8'h30);
        wr(19'h00000, 8'hB0);
        chk("R6 erase plus suspend", reqv, Q_SECT | Q_SUSP);
        chk("R6 mask", sect_mask, 8'h80);
        wr(19'h00000, 8'h30);
        chk("R6 suspended after window", reqv, Q_RES);
        done_pulse();

        // random non-unlock writes in read mode (R8, R13)
        for (int i = 0; i < 300; i++) begin
            d = 8'($urandom);
            if (($urandom % 4) == 0) d = 8'hF0;
            if (d == 8'hAA) d = 8'hAB;
            a = 19'($urandom);
            wr(a, d);
            chk("R8 random idle write", reqv, idle_expect(d));
        end
        chk("R8 random id mode clear", id_active, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule